// File: doc/BRIEF.md
# Warp Issue Scheduler

The scheduler sits inside one streaming multiprocessor and, every clock cycle, names the single resident warp that may issue its next instruction. Each warp slot presents an active bit, meaning a block's warp is resident here, and four hold-off bits: waiting on instruction fetch, a memory result, an execution result, or a barrier. A warp is eligible when it is active and none of its hold-off bits is set. The scheduler issues at most one eligible warp per cycle.

Selection is combinational from the current inputs and one stored pointer. The block can therefore move to a different warp on the very next cycle with no bubble. Among eligible warps the choice rotates, beginning just past the warp issued most recently.

When resident warps exist but none is eligible, the cycle is a stall. The block raises a stall flag and adds one to a per-reason counter, so that lost issue slots can be attributed to their cause. A cycle with no resident warp at all is idle and is not charged as a stall.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset all four counters read zero, and the first warp issued is the lowest-numbered eligible warp.
- R2: A warp is eligible only when its active bit is 1 and its fetch, memory, execution and barrier bits are all 0. `issue_valid` is 1 exactly when at least one warp is eligible, and `issue_warp` always names an eligible warp.
- R3: The next warp issued is the first eligible one found by searching upward from the warp issued last, plus one, and wrapping from the highest index back to 0.
- R4: With several warps staying eligible, a different warp issues on every consecutive cycle, with no cycle lost between them.
- R5: `stall` is 1 exactly when at least one warp is active and none is eligible. While `stall` is 1, `issue_valid` is 0.
- R6: With no active warp, both `issue_valid` and `stall` are 0, and the counters do not change, whatever the hold-off bits are.
- R7: On a stall cycle exactly one counter increases by one. It is the counter of the highest-priority reason set on the lowest-numbered active warp, with priority fetch, then memory, then execution, then barrier. No counter changes on a cycle that is not a stall.
- R8: Hold-off bits of inactive warps have no effect on selection.
- R9: Each counter saturates at its all-ones value.
- R10: Stall cycles and idle cycles leave the rotation pointer unchanged, so after a stall the search resumes after the warp issued before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_active | input | NUM_WARPS | Resident flag per warp slot |
| wait_fetch | input | NUM_WARPS | Warp waits on instruction fetch |
| wait_mem | input | NUM_WARPS | Warp waits on a memory dependency |
| wait_exec | input | NUM_WARPS | Warp waits on an execution dependency |
| wait_bar | input | NUM_WARPS | Warp waits at a synchronization barrier |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the issuing warp |
| stall | output | 1 | Resident warps exist but none can issue |
| cnt_fetch | output | CNT_W | Stall cycles charged to instruction fetch |
| cnt_mem | output | CNT_W | Stall cycles charged to memory |
| cnt_exec | output | CNT_W | Stall cycles charged to execution |
| cnt_bar | output | CNT_W | Stall cycles charged to barriers |

## Verification
A fully eligible set of warps shows that the rotation walks every index in order and wraps without a lost cycle. A sparse active mask shows that the rotation skips gaps. Masks in which all but one warp are held off, or in which stall bits sit on inactive slots, separate the eligibility rule from the active bits alone. The stall tests load the lowest active warp with several reasons at once, and removing them one at a time exposes the order of priority. A run of stalls long enough to fill a narrow counter checks saturation, and an all-idle cycle checks that idle cycles are not charged.

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 8,
  parameter int CNT_W     = 16,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_active,
  input  logic [NUM_WARPS-1:0] wait_fetch,
  input  logic [NUM_WARPS-1:0] wait_mem,
  input  logic [NUM_WARPS-1:0] wait_exec,
  input  logic [NUM_WARPS-1:0] wait_bar,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic                 stall,
  output logic [CNT_W-1:0]     cnt_fetch,
  output logic [CNT_W-1:0]     cnt_mem,
  output logic [CNT_W-1:0]     cnt_exec,
  output logic [CNT_W-1:0]     cnt_bar
);

  logic [NUM_WARPS-1:0] elig;
  logic [WID_W-1:0]     last_q;
  logic [WID_W-1:0]     pick;
  logic                 found;
  logic [3:0]           cause;
  logic [CNT_W-1:0]     cnt_q [4];

  assign elig = warp_active & ~(wait_fetch | wait_mem | wait_exec | wait_bar);

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      int idx;
      idx = (int'(last_q) + i) % NUM_WARPS;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = WID_W'(idx);
      end
    end
  end

  always_comb begin
    logic seen;
    seen  = 1'b0;
    cause = 4'b0000;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (!seen && warp_active[i]) begin
        seen = 1'b1;
        if (wait_fetch[i])     cause = 4'b0001;
        else if (wait_mem[i])  cause = 4'b0010;
        else if (wait_exec[i]) cause = 4'b0100;
        else if (wait_bar[i])  cause = 4'b1000;
      end
    end
  end

  assign issue_valid = found;
  assign issue_warp  = pick;
  assign stall       = (|warp_active) && !found;

  always_ff @(posedge clk) begin
    if (!rst_n)           last_q <= WID_W'(NUM_WARPS - 1);
    else if (issue_valid) last_q <= pick;
  end

  for (genvar k = 0; k < 4; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q[k] <= '0;
      else if (stall && cause[k] && (cnt_q[k] != {CNT_W{1'b1}}))
        cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign cnt_fetch = cnt_q[0];
  assign cnt_mem   = cnt_q[1];
  assign cnt_exec  = cnt_q[2];
  assign cnt_bar   = cnt_q[3];

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 8,
  parameter int CNT_W     = 16,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] warp_active,
  input logic [NUM_WARPS-1:0] wait_fetch,
  input logic [NUM_WARPS-1:0] wait_mem,
  input logic [NUM_WARPS-1:0] wait_exec,
  input logic [NUM_WARPS-1:0] wait_bar,
  input logic                 issue_valid,
  input logic [WID_W-1:0]     issue_warp,
  input logic                 stall,
  input logic [CNT_W-1:0]     cnt_fetch,
  input logic [CNT_W-1:0]     cnt_mem,
  input logic [CNT_W-1:0]     cnt_exec,
  input logic [CNT_W-1:0]     cnt_bar
);

  logic [CNT_W+1:0] total;
  logic             none_full;
  logic             any_ready;

  assign total = (CNT_W+2)'(cnt_fetch) + (CNT_W+2)'(cnt_mem)
               + (CNT_W+2)'(cnt_exec) + (CNT_W+2)'(cnt_bar);
  assign none_full = (cnt_fetch != '1) && (cnt_mem != '1)
                  && (cnt_exec != '1) && (cnt_bar != '1);
  assign any_ready = |(warp_active & ~wait_fetch & ~wait_mem & ~wait_exec & ~wait_bar);

  // R2
  issued_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (warp_active[issue_warp] && !wait_fetch[issue_warp] &&
                     !wait_mem[issue_warp] && !wait_exec[issue_warp] && !wait_bar[issue_warp]));

  // R4
  ready_means_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_ready |-> issue_valid);

  // R5
  stall_excludes_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!issue_valid && (|warp_active)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|warp_active) |-> (!issue_valid && !stall));

  // R7
  counters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> $stable(total));

  // R7
  single_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && none_full) |=> (total == $past(total) + 1'b1));

endmodule

bind warp_issue_sched warp_issue_sched_chk #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .warp_active(warp_active),
  .wait_fetch(wait_fetch), .wait_mem(wait_mem), .wait_exec(wait_exec), .wait_bar(wait_bar),
  .issue_valid(issue_valid), .issue_warp(issue_warp), .stall(stall),
  .cnt_fetch(cnt_fetch), .cnt_mem(cnt_mem), .cnt_exec(cnt_exec), .cnt_bar(cnt_bar)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
  localparam int N = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] act = '0, sf = '0, sm = '0, se = '0, sb = '0;
  logic issue_valid, stall;
  logic [2:0] issue_warp;
  logic [CW-1:0] c_f, c_m, c_e, c_b;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .warp_active(act),
    .wait_fetch(sf), .wait_mem(sm), .wait_exec(se), .wait_bar(sb),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .stall(stall),
    .cnt_fetch(c_f), .cnt_mem(c_m), .cnt_exec(c_e), .cnt_bar(c_b)
  );

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    act = '0; sf = '0; sm = '0; se = '0; sb = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    apply_reset();
    #1;
    chk("R1 cnt_fetch", c_f, 0); chk("R1 cnt_mem", c_m, 0);
    chk("R1 cnt_exec", c_e, 0);  chk("R1 cnt_bar", c_b, 0);
    act = 8'b1010_0000;
    #1;
    chk("R1 first valid", issue_valid, 1);
    chk("R1 first warp", issue_warp, 5);
  endtask

  task automatic t_rr_full();
    apply_reset();
    act = 8'hFF;
    for (int k = 0; k < 9; k++) begin
      #1;
      chk("R4 valid each cycle", issue_valid, 1);
      chk("R3 R4 rotation", issue_warp, k % 8);
      step();
    end
  endtask

  task automatic t_rr_sparse();
    apply_reset();
    act = 8'b1001_0010;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R3 sparse rotation", issue_warp, (k % 3 == 0) ? 1 : (k % 3 == 1) ? 4 : 7);
      step();
    end
  endtask

  task automatic t_elig();
    apply_reset();
    act = 8'hFF; sm = 8'h7F;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R2 only eligible warp", issue_warp, 7);
      chk("R2 valid", issue_valid, 1);
      step();
    end
    act = 8'h0C; sm = '0; sf = 8'hF3; sb = 8'hF3;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R8 inactive bits ignored", issue_warp, (k % 2 == 0) ? 2 : 3);
      chk("R8 valid", issue_valid, 1);
      chk("R8 no stall", stall, 0);
      step();
    end
  endtask

  task automatic t_stall_causes();
    apply_reset();
    act = 8'h06; se = 8'h02; sf = 8'h04;
    #1;
    chk("R5 stall", stall, 1);
    chk("R5 no issue", issue_valid, 0);
    step();
    chk("R7 exec charged", c_e, 1);
    chk("R7 fetch not charged", c_f, 0);
    sf = 8'h06; sm = 8'h02; se = 8'h02; sb = 8'h02;
    step();
    chk("R7 fetch first", c_f, 1);
    chk("R7 mem untouched", c_m, 0);
    sf = 8'h04;
    step();
    chk("R7 mem second", c_m, 1);
    chk("R7 exec unchanged", c_e, 1);
    sm = '0; se = '0;
    step();
    chk("R7 bar last", c_b, 1);
    chk("R7 fetch unchanged", c_f, 1);
  endtask

  task automatic t_idle();
    apply_reset();
    act = 8'h01; sb = 8'h01;
    step();
    act = '0; sf = 8'hFF; sm = 8'hFF; se = 8'hFF; sb = 8'hFF;
    #1;
    chk("R6 no issue", issue_valid, 0);
    chk("R6 no stall", stall, 0);
    repeat (3) step();
    chk("R6 bar held", c_b, 1);
    chk("R6 fetch held", c_f, 0);
  endtask

  task automatic t_hold();
    apply_reset();
    act = 8'hFF;
    #1;
    chk("R10 first", issue_warp, 0);
    step();
    sb = 8'hFF;
    #1;
    chk("R10 stalled", stall, 1);
    repeat (2) step();
    act = '0;
    step();
    act = 8'hFF; sb = '0;
    #1;
    chk("R10 resume after last", issue_warp, 1);
  endtask

  task automatic t_sat();
    apply_reset();
    act = 8'h01; sf = 8'h01;
    repeat (9) step();
    chk("R9 saturated", c_f, 7);
    chk("R9 others zero", c_m + c_e + c_b, 0);
  endtask

  initial begin
    t_reset();
    t_rr_full();
    t_rr_sparse();
    t_elig();
    t_stall_causes();
    t_idle();
    t_hold();
    t_sat();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule